// File: doc/BRIEF.md
# Optical Module Alarm Monitor

This block watches five digitized operating readings of an optical transceiver: temperature, laser bias current, transmit optical power, receive optical power and supply voltage. Each reading is compared against four programmable limits, and any excursion raises a latched flag. A host clears the flags with a pulse once the cause has gone away. The host loads the limits through a simple write port.

The block also drives the module status pins. A transmit fault is raised when the bias current or the transmit power goes above its high alarm limit. The fault stays latched until the transmitter is disabled, and it is not evaluated again until a set number of samples after re-enable. The laser enable follows the inverse of the transmit disable input. An undriven disable is expected to reach this block as logic 1, which keeps the laser off. The loss-of-signal output is the inverse of the receiver's signal-detect input.

Top module: `optmon_top`

## Requirements
- R1: While and right after reset, all sixteen-bit flag vectors, `tx_fault` and `laser_en` are 0, and `rx_los` is 1. High limits reset to 0xFFFF and low limits reset to 0, so no reading raises a flag before the limits are loaded.
- R2: A cycle with `thr_we`=1 loads `thr_wdata` into the limit chosen by `thr_sel` and `thr_kind`. Channel codes are 0 temperature, 1 bias, 2 transmit power, 3 receive power and 4 supply. Kind codes are 0 high alarm, 1 low alarm, 2 high warning and 3 low warning. A write with a channel code of 5 or above changes no limit.
- R3: Comparisons are unsigned and strict. A high flag is set only when the reading is greater than its limit, and a low flag only when the reading is less than its limit. A reading equal to a limit sets nothing.
- R4: Flags are sticky and stay set after the reading returns inside its limits.
- R5: A `flag_clr` pulse sets each flag to that flag's condition as evaluated on the most recent sample before the pulse. A flag whose condition has cleared goes to 0, and a flag whose condition still holds stays at 1.
- R6: `tx_fault` is set on a sample where channel 1 or channel 2 is above its high alarm limit, once the hold-off has ended. Alarms and warnings on any other channel, and low or warning conditions on channels 1 and 2, never set it.
- R7: Once set, `tx_fault` stays at 1 whatever the samples or `flag_clr` do, until `tx_disable_in` is 1. It goes to 0 on the cycle after `tx_disable_in` goes to 1 and stays 0 while the input remains 1.
- R8: After reset, and after `tx_disable_in` returns to 0, the first two valid samples are not evaluated for the fault. The third sample and later ones are evaluated.
- R9: `laser_en` equals the inverse of `tx_disable_in` and `rx_los` equals the inverse of `rx_sig_detect`, each with one cycle of latency.
- R10: Flags change only on the cycle after a `sample_valid` or a `flag_clr`. In all other cycles they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe marking a new set of readings |
| sample_data | input | 80 | Five 16-bit readings; channel i sits in bits [16i+15:16i] |
| thr_we | input | 1 | Limit write strobe |
| thr_sel | input | 3 | Channel code of the limit to write |
| thr_kind | input | 2 | Kind code of the limit to write |
| thr_wdata | input | 16 | Limit value |
| flag_clr | input | 1 | Host flag-clear pulse |
| tx_disable_in | input | 1 | Transmit disable; 1 turns the laser off |
| rx_sig_detect | input | 1 | Receiver signal present |
| alarm_hi | output | 5 | Latched high alarm flag per channel |
| alarm_lo | output | 5 | Latched low alarm flag per channel |
| warn_hi | output | 5 | Latched high warning flag per channel |
| warn_lo | output | 5 | Latched low warning flag per channel |
| tx_fault | output | 1 | Latched transmit fault |
| laser_en | output | 1 | Laser enable |
| rx_los | output | 1 | Loss of signal |

## Verification
The assertions assume that `tx_disable_in` and `rx_sig_detect` are already synchronous to `clk`. They also assume that the sample strobe is a single-cycle pulse and that the flag-clear pulse never lands in the same cycle as a sample, so that each flag change can be traced to one cause. The stimulus drives every input on the falling edge, never asserts `flag_clr` together with `sample_valid`, and keeps limit writes in cycles apart from samples.

// File: rtl/optmon_pkg.sv
// Shared types and channel numbering for the optical module alarm monitor.
// Assumes four limits per channel, with even kind codes being high limits.
package optmon_pkg;

    localparam int unsigned NKIND = 4;

    // Limit kind code presented on the write port
    typedef enum logic [1:0] {
        THR_HI_ALM = 2'd0,
        THR_LO_ALM = 2'd1,
        THR_HI_WRN = 2'd2,
        THR_LO_WRN = 2'd3
    } thr_kind_e;

    // Four condition bits kept for each channel
    typedef struct packed {
        logic hi_alm;
        logic lo_alm;
        logic hi_wrn;
        logic lo_wrn;
    } flagset_t;

    // Channel positions whose numbering the transmit fault depends on
    localparam int unsigned CH_TEMP  = 0;
    localparam int unsigned CH_BIAS  = 1;
    localparam int unsigned CH_TXPWR = 2;
    localparam int unsigned CH_RXPWR = 3;
    localparam int unsigned CH_VCC   = 4;

endpackage

// File: rtl/optmon_thr_bank.sv
// Limit register bank: NCH channels with NKIND limits each, loaded by a write
// strobe. High limits reset to all ones and low limits reset to zero, so
// nothing trips before the limits are loaded. A write to a channel code at or
// above NCH matches no register and is dropped.
module optmon_thr_bank
    import optmon_pkg::*;
#(
    parameter int unsigned NCH  = 5,
    parameter int unsigned DW   = 16,
    parameter int unsigned SELW = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SELW-1:0]           wr_sel,
    input  logic [1:0]                wr_kind,
    input  logic [DW-1:0]             wr_data,
    output logic [NCH*NKIND*DW-1:0]   thr_flat
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        for (genvar k = 0; k < NKIND; k++) begin : g_kind
            localparam logic [DW-1:0] RST_VAL = ((k % 2) == 0) ? {DW{1'b1}} : {DW{1'b0}};
            localparam int unsigned   POS     = (ch * NKIND + k) * DW;
            logic [DW-1:0] lim_q;

            // Hold one limit; load it when the write address matches
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lim_q <= RST_VAL;
                end else if (wr_en && (wr_sel == SELW'(ch)) && (wr_kind == 2'(k))) begin
                    lim_q <= wr_data;
                end
            end

            assign thr_flat[POS +: DW] = lim_q;
        end
    end

endmodule

// File: rtl/optmon_chan.sv
// One monitored channel: strict unsigned comparison of a reading against its
// four limits, plus sticky flags. A clear pulse reloads each flag from the
// condition seen on the most recent sample. Assumes sample_valid is a
// one-cycle strobe. When TX_SRC is set, the channel also reports its
// instantaneous high-alarm condition for the transmit fault.
module optmon_chan
    import optmon_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter bit          TX_SRC = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_valid,
    input  logic          flag_clr,
    input  logic [DW-1:0] reading,
    input  logic [DW-1:0] lim_hi_alm,
    input  logic [DW-1:0] lim_lo_alm,
    input  logic [DW-1:0] lim_hi_wrn,
    input  logic [DW-1:0] lim_lo_wrn,
    output flagset_t      flags,
    output logic          trip_now
);

    flagset_t cond_now;
    flagset_t cond_q;
    flagset_t flags_q;
    flagset_t clr_mask;
    flagset_t smp_mask;

    // Strict comparisons of the current reading against each limit
    always_comb begin
        cond_now.hi_alm = reading > lim_hi_alm;
        cond_now.lo_alm = reading < lim_lo_alm;
        cond_now.hi_wrn = reading > lim_hi_wrn;
        cond_now.lo_wrn = reading < lim_lo_wrn;
    end

    // Expand the strobes to the four flag bits
    always_comb begin
        clr_mask = flag_clr     ? 4'b1111 : 4'b0000;
        smp_mask = sample_valid ? 4'b1111 : 4'b0000;
    end

    // Remember the condition of the last sample, for use by the clear pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= '0;
        end else if (sample_valid) begin
            cond_q <= cond_now;
        end
    end

    // Sticky flags: set by a sample, reloaded from the last condition on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (sample_valid || flag_clr) begin
            flags_q <= (flags_q & ~clr_mask) | (cond_q & clr_mask) | (cond_now & smp_mask);
        end
    end

    assign flags = flags_q;

    if (TX_SRC) begin : g_src
        assign trip_now = cond_now.hi_alm;
    end else begin : g_nosrc
        assign trip_now = 1'b0;
    end

endmodule

// File: rtl/optmon_txctl.sv
// Transmit fault, laser enable and loss-of-signal outputs. The fault latches
// on a qualified trip and is cleared only while transmit disable is high. A
// hold-off counter skips the first HOLD_SAMPLES samples after reset or after
// re-enable. Assumes the disable and signal-detect inputs are already
// synchronous to clk.
module optmon_txctl #(
    parameter int unsigned HOLD_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_valid,
    input  logic trip,
    input  logic tx_disable_in,
    input  logic rx_sig_detect,
    output logic tx_fault,
    output logic laser_en,
    output logic rx_los
);

    localparam int unsigned HW = $clog2(HOLD_SAMPLES + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_SAMPLES);

    logic [HW-1:0] hold_q;
    logic          fault_q;
    logic          hold_done;

    assign hold_done = (hold_q == '0);

    // Hold-off count: reload while disabled, count samples down once enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= HOLD_LOAD;
        end else if (tx_disable_in) begin
            hold_q <= HOLD_LOAD;
        end else if (sample_valid && !hold_done) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    // Latched fault: clear on disable, set on a trip once the hold-off is over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (tx_disable_in) begin
            fault_q <= 1'b0;
        end else if (sample_valid && hold_done && trip) begin
            fault_q <= 1'b1;
        end
    end

    // Register the pin-level laser enable and loss-of-signal outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            laser_en <= 1'b0;
            rx_los   <= 1'b1;
        end else begin
            laser_en <= !tx_disable_in;
            rx_los   <= !rx_sig_detect;
        end
    end

    assign tx_fault = fault_q;

endmodule

// File: rtl/optmon_top.sv
// Optical module alarm monitor top. It holds the limit bank and one compare
// channel per reading, and feeds the transmit control with the high-alarm
// trips of the bias and transmit-power channels. Assumes NCH covers both of
// those channel positions.
module optmon_top
    import optmon_pkg::*;
#(
    parameter int unsigned NCH          = 5,
    parameter int unsigned DW           = 16,
    parameter int unsigned SELW         = 3,
    parameter int unsigned HOLD_SAMPLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [NCH*DW-1:0] sample_data,
    input  logic              thr_we,
    input  logic [SELW-1:0]   thr_sel,
    input  logic [1:0]        thr_kind,
    input  logic [DW-1:0]     thr_wdata,
    input  logic              flag_clr,
    input  logic              tx_disable_in,
    input  logic              rx_sig_detect,
    output logic [NCH-1:0]    alarm_hi,
    output logic [NCH-1:0]    alarm_lo,
    output logic [NCH-1:0]    warn_hi,
    output logic [NCH-1:0]    warn_lo,
    output logic              tx_fault,
    output logic              laser_en,
    output logic              rx_los
);

    localparam int unsigned LIMW = NKIND * DW;

    logic [NCH*LIMW-1:0] thr_flat;
    logic [NCH-1:0]      trip_vec;
    logic                trip_any;

    optmon_thr_bank #(
        .NCH  (NCH),
        .DW   (DW),
        .SELW (SELW)
    ) u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (thr_we),
        .wr_sel   (thr_sel),
        .wr_kind  (thr_kind),
        .wr_data  (thr_wdata),
        .thr_flat (thr_flat)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam int unsigned BASE = ch * LIMW;
        localparam bit IS_SRC = (ch == CH_BIAS) || (ch == CH_TXPWR);
        flagset_t fl;

        optmon_chan #(
            .DW     (DW),
            .TX_SRC (IS_SRC)
        ) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample_valid (sample_valid),
            .flag_clr     (flag_clr),
            .reading      (sample_data[ch*DW +: DW]),
            .lim_hi_alm   (thr_flat[BASE + int'(THR_HI_ALM)*DW +: DW]),
            .lim_lo_alm   (thr_flat[BASE + int'(THR_LO_ALM)*DW +: DW]),
            .lim_hi_wrn   (thr_flat[BASE + int'(THR_HI_WRN)*DW +: DW]),
            .lim_lo_wrn   (thr_flat[BASE + int'(THR_LO_WRN)*DW +: DW]),
            .flags        (fl),
            .trip_now     (trip_vec[ch])
        );

        assign alarm_hi[ch] = fl.hi_alm;
        assign alarm_lo[ch] = fl.lo_alm;
        assign warn_hi[ch]  = fl.hi_wrn;
        assign warn_lo[ch]  = fl.lo_wrn;
    end

    assign trip_any = |trip_vec;

    optmon_txctl #(
        .HOLD_SAMPLES (HOLD_SAMPLES)
    ) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_valid  (sample_valid),
        .trip          (trip_any),
        .tx_disable_in (tx_disable_in),
        .rx_sig_detect (rx_sig_detect),
        .tx_fault      (tx_fault),
        .laser_en      (laser_en),
        .rx_los        (rx_los)
    );

endmodule

// File: rtl/optmon_chk.sv
// Assertion checker for optmon_top, attached by bind. Assumes inputs are
// synchronous to clk and that the clear pulse never coincides with a sample.
module optmon_chk #(
    parameter int unsigned NCH = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sample_valid,
    input logic           flag_clr,
    input logic           tx_disable_in,
    input logic           rx_sig_detect,
    input logic [NCH-1:0] alarm_hi,
    input logic [NCH-1:0] alarm_lo,
    input logic [NCH-1:0] warn_hi,
    input logic [NCH-1:0] warn_lo,
    input logic           tx_fault,
    input logic           laser_en,
    input logic           rx_los
);

    logic past_ok;

    // Mark that one clock has passed out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RESET_OUTPUTS: assert property (@(posedge clk) !rst_n |=> (tx_fault == 1'b0) && (alarm_hi == '0) && rx_los); // R1

    AST_FAULT_CLEAR_ON_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(tx_disable_in) |-> !tx_fault); // R7

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(tx_fault) && !$past(tx_disable_in) |-> tx_fault); // R7

    AST_FAULT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(tx_fault) |-> $past(sample_valid)); // R6

    AST_LASER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (laser_en == !$past(tx_disable_in))); // R9

    AST_LOS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rx_los == !$past(rx_sig_detect))); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(sample_valid) && !$past(flag_clr) |->
        $stable(alarm_hi) && $stable(alarm_lo) && $stable(warn_hi) && $stable(warn_lo)); // R10

    AST_FLAGS_RISE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(sample_valid) |->
        (((alarm_hi & ~$past(alarm_hi)) | (alarm_lo & ~$past(alarm_lo)) |
          (warn_hi & ~$past(warn_hi)) | (warn_lo & ~$past(warn_lo))) == '0)); // R4

endmodule

bind optmon_top optmon_chk #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_valid  (sample_valid),
    .flag_clr      (flag_clr),
    .tx_disable_in (tx_disable_in),
    .rx_sig_detect (rx_sig_detect),
    .alarm_hi      (alarm_hi),
    .alarm_lo      (alarm_lo),
    .warn_hi       (warn_hi),
    .warn_lo       (warn_lo),
    .tx_fault      (tx_fault),
    .laser_en      (laser_en),
    .rx_los        (rx_los)
);

// File: tb/sim_optmon_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver tasks step a requirement-level model and push
// the expected outputs; a monitor pops and compares them on the falling edge.
module sim_optmon_top;

    localparam int NCH  = 5;
    localparam int DW   = 16;
    localparam int TCLK = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_valid = 1'b0;
    logic [NCH*DW-1:0] sample_data = '0;
    logic              thr_we = 1'b0;
    logic [2:0]        thr_sel = '0;
    logic [1:0]        thr_kind = '0;
    logic [DW-1:0]     thr_wdata = '0;
    logic              flag_clr = 1'b0;
    logic              tx_disable_in = 1'b1;
    logic              rx_sig_detect = 1'b0;
    logic [NCH-1:0]    alarm_hi, alarm_lo, warn_hi, warn_lo;
    logic              tx_fault, laser_en, rx_los;

    always #(TCLK/2) clk = ~clk;

    optmon_top u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_data(sample_data),
        .thr_we(thr_we), .thr_sel(thr_sel), .thr_kind(thr_kind), .thr_wdata(thr_wdata),
        .flag_clr(flag_clr), .tx_disable_in(tx_disable_in), .rx_sig_detect(rx_sig_detect),
        .alarm_hi(alarm_hi), .alarm_lo(alarm_lo), .warn_hi(warn_hi), .warn_lo(warn_lo),
        .tx_fault(tx_fault), .laser_en(laser_en), .rx_los(rx_los)
    );

    typedef struct {
        logic [NCH-1:0] ahi, alo, whi, wlo;
        logic           flt, len, los;
        string          tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;

    // Model state; flag bit order {hi alarm, lo alarm, hi warning, lo warning}
    logic [DW-1:0] m_thr[NCH][4];
    logic [3:0]    m_cond[NCH];
    logic [3:0]    m_flag[NCH];
    logic          m_flt = 1'b0, m_len = 1'b0, m_los = 1'b1;
    int            m_hold = 2;
    logic          t_dis = 1'b1, t_sd = 1'b0;

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_thr[i][0] = 16'hFFFF; m_thr[i][1] = 16'h0;
            m_thr[i][2] = 16'hFFFF; m_thr[i][3] = 16'h0;
            m_cond[i] = '0; m_flag[i] = '0;
        end
    end

    function automatic logic [NCH*DW-1:0] pk(int a, int b, int c, int d, int e);
        return {16'(e), 16'(d), 16'(c), 16'(b), 16'(a)};
    endfunction

    // Drive one cycle, advance the model and push the expected outputs
    task automatic cycle(input logic sv, input logic [NCH*DW-1:0] data, input logic clr,
                         input logic we, input logic [2:0] sel, input logic [1:0] kind,
                         input logic [DW-1:0] wd, input string tag);
        exp_t e;
        logic [3:0] nc[NCH];
        @(negedge clk);
        sample_valid = sv; sample_data = data; flag_clr = clr;
        thr_we = we; thr_sel = sel; thr_kind = kind; thr_wdata = wd;
        tx_disable_in = t_dis; rx_sig_detect = t_sd;
        for (int i = 0; i < NCH; i++) begin
            logic [DW-1:0] v;
            v = data[i*DW +: DW];
            nc[i] = {v > m_thr[i][0], v < m_thr[i][1], v > m_thr[i][2], v < m_thr[i][3]};
            m_flag[i] = (m_flag[i] & ~{4{clr}}) | ({4{clr}} & m_cond[i]) | ({4{sv}} & nc[i]);
            if (sv) m_cond[i] = nc[i];
        end
        if (t_dis) begin
            m_flt = 1'b0; m_hold = 2;
        end else if (sv) begin
            if (m_hold > 0) m_hold--;
            else if (nc[1][3] || nc[2][3]) m_flt = 1'b1;
        end
        if (we && sel < NCH) m_thr[sel][kind] = wd;
        m_len = !t_dis; m_los = !t_sd;
        for (int i = 0; i < NCH; i++) begin
            e.ahi[i] = m_flag[i][3]; e.alo[i] = m_flag[i][2];
            e.whi[i] = m_flag[i][1]; e.wlo[i] = m_flag[i][0];
        end
        e.flt = m_flt; e.len = m_len; e.los = m_los; e.tag = tag;
        @(posedge clk);
        #1;
        q.push_back(e);
    endtask

    task automatic smp(int a, int b, int c, int d, int e, string tag);
        cycle(1'b1, pk(a, b, c, d, e), 1'b0, 1'b0, 3'd0, 2'd0, 16'd0, tag);
    endtask

    task automatic wthr(int sel, int kind, int val, string tag);
        cycle(1'b0, '0, 1'b0, 1'b1, 3'(sel), 2'(kind), 16'(val), tag);
    endtask

    task automatic idle(string tag);
        cycle(1'b0, '0, 1'b0, 1'b0, 3'd0, 2'd0, 16'd0, tag);
    endtask

    task automatic clr(string tag);
        cycle(1'b0, '0, 1'b1, 1'b0, 3'd0, 2'd0, 16'd0, tag);
    endtask

    task automatic nominal(string tag);
        smp(500, 1000, 1000, 1000, 3300, tag);
    endtask

    // Monitor: compare each expected item with the outputs between edges
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (alarm_hi !== e.ahi || alarm_lo !== e.alo || warn_hi !== e.whi ||
                    warn_lo !== e.wlo || tx_fault !== e.flt || laser_en !== e.len ||
                    rx_los !== e.los) begin
                    errors++;
                    $display("FAIL %s: got ahi=%b alo=%b whi=%b wlo=%b flt=%b len=%b los=%b, expected ahi=%b alo=%b whi=%b wlo=%b flt=%b len=%b los=%b",
                             e.tag, alarm_hi, alarm_lo, warn_hi, warn_lo, tx_fault, laser_en, rx_los,
                             e.ahi, e.alo, e.whi, e.wlo, e.flt, e.len, e.los);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(TCLK * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        checks++;
        if (alarm_hi !== '0 || alarm_lo !== '0 || warn_hi !== '0 || warn_lo !== '0 ||
            tx_fault !== 1'b0 || laser_en !== 1'b0 || rx_los !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: got flt=%b len=%b los=%b ahi=%b, expected flt=0 len=0 los=1 ahi=0",
                     tx_fault, laser_en, rx_los, alarm_hi);
        end
        rst_n = 1'b1;
        idle("R1 first cycle out of reset");
        smp(65535, 65535, 65535, 0, 0, "R1 default limits raise nothing");
        t_dis = 1'b0; t_sd = 1'b1;
        idle("R9 laser on and signal present");
        // R2: load limits; channel codes 0..4, kinds 0 hi alm,1 lo alm,2 hi wrn,3 lo wrn
        wthr(0, 0, 1000, "R2 write"); wthr(0, 1, 100, "R2 write");
        wthr(0, 2, 800, "R2 write");  wthr(0, 3, 200, "R2 write");
        wthr(1, 0, 5000, "R2 write"); wthr(1, 2, 4000, "R2 write");
        wthr(2, 0, 6000, "R2 write"); wthr(2, 2, 5000, "R2 write");
        wthr(3, 0, 3000, "R2 write"); wthr(3, 1, 50, "R2 write");
        wthr(3, 2, 2500, "R2 write"); wthr(3, 3, 60, "R2 write");
        wthr(4, 0, 3600, "R2 write"); wthr(4, 1, 2900, "R2 write");
        wthr(4, 2, 3500, "R2 write"); wthr(4, 3, 3000, "R2 write");
        wthr(5, 0, 0, "R2 out-of-range channel write");
        wthr(7, 2, 0, "R2 out-of-range channel write");
        nominal("R2 nominal readings raise nothing after out-of-range writes");
        nominal("R8 second sample inside hold-off");
        smp(1000, 1000, 1000, 1000, 2900, "R3 equal to alarm limits: warnings only");
        smp(1001, 1000, 1000, 1000, 3300, "R3 one above temperature high alarm");
        nominal("R4 flags stay after return to range");
        idle("R10 no event holds flags");
        clr("R5 clear with condition gone");
        smp(500, 1000, 1000, 40, 3300, "R3 receive power below low limits");
        clr("R5 clear with condition persisting");
        nominal("R4 low flags stay");
        clr("R5 second clear after recovery");
        smp(2000, 1000, 1000, 3500, 3300, "R6 other channel alarms do not fault");
        smp(500, 4500, 5500, 1000, 3300, "R6 warnings on sources do not fault");
        smp(500, 5000, 1000, 1000, 3300, "R6 bias equal to alarm does not fault");
        smp(500, 5001, 1000, 1000, 3300, "R6 bias above alarm faults");
        nominal("R7 fault latched after recovery");
        clr("R7 clear pulse leaves fault");
        t_dis = 1'b1;
        idle("R7 disable clears fault");
        smp(500, 9000, 9000, 1000, 3300, "R7 fault held low while disabled");
        t_dis = 1'b0;
        idle("R9 laser back on");
        smp(500, 1000, 7000, 1000, 3300, "R8 first sample after enable ignored");
        smp(500, 1000, 7000, 1000, 3300, "R8 second sample after enable ignored");
        idle("R8 idle cycle does not count");
        smp(500, 1000, 7000, 1000, 3300, "R8 third sample evaluated: txpwr fault");
        t_sd = 1'b0;
        idle("R9 signal lost");
        t_sd = 1'b1;
        idle("R9 signal back");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule